// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive buffer takes an incoming CAN frame. Once the arbitration field of a frame has been received, the receive logic presents the identifier and the IDE, RTR and reserved bits together with a one-cycle valid strobe. Fifteen filter slots, one per message object, each compare that field against their own tag under their own mask. The block reports the complete set of slots that matched and names a single owner.

Each slot is configured as an 11-bit standard filter or a 29-bit extended filter. Separate enables decide whether the slot compares the RTR bit and whether it insists on the IDE bit. A slot that is switched off, or that is set up to transmit, never matches. When several receive slots match the same frame, the lowest-numbered slot owns it. The result is captured in the clock after the strobe and stays unchanged until the next strobe.

Top module: `can_accept_filter`

## Requirements
- R1: The outputs `hit_o`, `hit_idx_o` and `hit_vec_o` are zero after reset. They take a new value at the first rising clock edge at which `frame_vld_i` is sampled high, so they are valid one clock after the strobe.
- R2: For each identifier bit that a slot compares, a mask bit of 1 requires the received bit to equal the tag bit, and a mask bit of 0 lets that bit take any value.
- R3: A standard slot (`cfg_ext_i` bit = 0) compares only identifier bits 28 to 18 of `rx_id_i` against the same tag bits. It never matches a frame whose IDE bit is 1.
- R4: An extended slot (`cfg_ext_i` bit = 1) compares all 29 identifier bits. When its `cfg_ide_chk_i` bit is 1, it matches only frames with IDE = 1. When that bit is 0, the IDE bit is ignored.
- R5: The received RTR bit must equal the slot's `cfg_rtr_tag_i` bit when the slot's `cfg_rtr_chk_i` bit is 1. When that bit is 0, RTR is ignored.
- R6: The received reserved bit must always equal the slot's `cfg_rb_tag_i` bit.
- R7: A slot whose `cfg_en_i` bit is 0, or whose `cfg_rx_i` bit is 0 (transmit), never sets its bit in `hit_vec_o` and is never chosen as owner.
- R8: `hit_vec_o` bit n is 1 exactly when slot n matched. When more than one slot matches, `hit_idx_o` is the lowest such n.
- R9: While `frame_vld_i` is low, all three outputs hold their values, even if the frame inputs and the configuration change.
- R10: A strobe that no slot matches gives `hit_o` = 0, `hit_idx_o` = 0 and `hit_vec_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe: the arbitration field is valid |
| rx_id_i | input | 29 | Received identifier; a standard identifier sits in bits 28:18 |
| rx_ide_i | input | 1 | Received IDE bit |
| rx_rtr_i | input | 1 | Received RTR bit |
| rx_rb_i | input | 1 | Received reserved bit |
| cfg_tag_i | input | NOBJ*29 | Identifier tag of each slot; slot n is at bits [n*29 +: 29] |
| cfg_msk_i | input | NOBJ*29 | Identifier mask of each slot (1 = compare) |
| cfg_rtr_tag_i | input | NOBJ | Expected RTR value of each slot |
| cfg_rb_tag_i | input | NOBJ | Expected reserved-bit value of each slot |
| cfg_ext_i | input | NOBJ | 1 = 29-bit extended slot, 0 = 11-bit standard slot |
| cfg_rtr_chk_i | input | NOBJ | 1 = the slot compares RTR |
| cfg_ide_chk_i | input | NOBJ | 1 = an extended slot requires IDE = 1 |
| cfg_en_i | input | NOBJ | Slot enable |
| cfg_rx_i | input | NOBJ | 1 = receive slot, 0 = transmit slot |
| hit_o | output | 1 | At least one slot matched the last strobed frame |
| hit_idx_o | output | $clog2(NOBJ) | Index of the owning slot |
| hit_vec_o | output | NOBJ | One bit per slot that matched |

## Verification
The bench builds the filter with NOBJ = 15, which is the full slot count. At that size the 4-bit owner index reaches its top value of 14, and the priority chain is exercised from end to end. Random frames are derived from a chosen slot's tag, flipping only the bits its mask lets through. This keeps hits frequent, and when several slots share the same tag the bench also produces matches on many slots at once. Directed frames cover the standard and extended formats, the RTR and IDE enables, the reserved bit, slots that are off or set to transmit, and output hold between strobes.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
    logic            rb;
  } arb_t;

  typedef struct packed {
    logic [ID_W-1:0] tag;
    logic [ID_W-1:0] msk;
    logic            rtr_tag;
    logic            rb_tag;
    logic            ext;
    logic            rtr_chk;
    logic            ide_chk;
    logic            en;
    logic            rx;
  } slot_cfg_t;

  // Identifier bits that take part in the compare for a given format
  function automatic logic [ID_W-1:0] id_span(input logic ext);
    return ext ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/can_af_cmp.sv
module can_af_cmp
  import can_af_pkg::*;
(
  input  arb_t      arb_i,
  input  slot_cfg_t cfg_i,
  output logic      match_o
);
  logic [ID_W-1:0] id_diff;
  logic            id_ok;
  logic            rtr_ok;
  logic            rb_ok;
  logic            ide_ok;
  logic            live;

  assign id_diff = (arb_i.id ^ cfg_i.tag) & cfg_i.msk & id_span(cfg_i.ext);
  assign id_ok   = (id_diff == '0);
  assign rtr_ok  = !cfg_i.rtr_chk || (arb_i.rtr == cfg_i.rtr_tag);
  assign rb_ok   = (arb_i.rb == cfg_i.rb_tag);
  // standard slot: IDE must be 0; extended slot: IDE must be 1 only when checked
  assign ide_ok  = cfg_i.ext ? (!cfg_i.ide_chk || arb_i.ide) : !arb_i.ide;
  assign live    = cfg_i.en && cfg_i.rx;

  assign match_o = live && id_ok && rtr_ok && rb_ok && ide_ok;

  always_comb begin
    if (!cfg_i.ext && arb_i.ide)
      AST_STD_NO_IDE: assert (!match_o); // R3
    if (!cfg_i.en || !cfg_i.rx)
      AST_OFF_SILENT: assert (!match_o); // R7
  end
endmodule

// File: rtl/can_af_prio.sv
module can_af_prio #(
  parameter  int NOBJ = 15,
  localparam int IDXW = (NOBJ > 1) ? $clog2(NOBJ) : 1
) (
  input  logic [NOBJ-1:0] vec_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NOBJ - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |vec_i;

  always_comb begin
    if (any_o) AST_IDX_SET: assert (vec_i[idx_o]); // R8
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter  int NOBJ = 15,
  localparam int IDXW = (NOBJ > 1) ? $clog2(NOBJ) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_vld_i,
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic                 rx_ide_i,
  input  logic                 rx_rtr_i,
  input  logic                 rx_rb_i,
  input  logic [NOBJ*ID_W-1:0] cfg_tag_i,
  input  logic [NOBJ*ID_W-1:0] cfg_msk_i,
  input  logic [NOBJ-1:0]      cfg_rtr_tag_i,
  input  logic [NOBJ-1:0]      cfg_rb_tag_i,
  input  logic [NOBJ-1:0]      cfg_ext_i,
  input  logic [NOBJ-1:0]      cfg_rtr_chk_i,
  input  logic [NOBJ-1:0]      cfg_ide_chk_i,
  input  logic [NOBJ-1:0]      cfg_en_i,
  input  logic [NOBJ-1:0]      cfg_rx_i,
  output logic                 hit_o,
  output logic [IDXW-1:0]      hit_idx_o,
  output logic [NOBJ-1:0]      hit_vec_o
);
  arb_t            arb;
  logic [NOBJ-1:0] match;
  logic            any_d;
  logic [IDXW-1:0] idx_d;

  assign arb = '{id: rx_id_i, ide: rx_ide_i, rtr: rx_rtr_i, rb: rx_rb_i};

  for (genvar g = 0; g < NOBJ; g++) begin : g_slot
    slot_cfg_t cfg;
    assign cfg = '{
      tag:     cfg_tag_i[g*ID_W +: ID_W],
      msk:     cfg_msk_i[g*ID_W +: ID_W],
      rtr_tag: cfg_rtr_tag_i[g],
      rb_tag:  cfg_rb_tag_i[g],
      ext:     cfg_ext_i[g],
      rtr_chk: cfg_rtr_chk_i[g],
      ide_chk: cfg_ide_chk_i[g],
      en:      cfg_en_i[g],
      rx:      cfg_rx_i[g]
    };
    can_af_cmp u_cmp (
      .arb_i   (arb),
      .cfg_i   (cfg),
      .match_o (match[g])
    );
  end

  can_af_prio #(.NOBJ(NOBJ)) u_prio (
    .vec_i (match),
    .any_o (any_d),
    .idx_o (idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      hit_vec_o <= '0;
    end else if (frame_vld_i) begin
      hit_o     <= any_d;
      hit_idx_o <= idx_d;
      hit_vec_o <= match;
    end
  end

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(hit_o) && $stable(hit_idx_o) && $stable(hit_vec_o)); // R9
  AST_FLAG_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (hit_vec_o != '0)); // R8
  AST_OWNER_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_vec_o[hit_idx_o] &&
              ((hit_vec_o & ((NOBJ'(1) << hit_idx_o) - NOBJ'(1))) == '0)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> hit_idx_o == '0); // R10
  AST_ONLY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> (hit_vec_o & ~$past(cfg_en_i & cfg_rx_i)) == '0); // R7
endmodule

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
  localparam int NOBJ = 15;
  localparam int IDW  = 29;
  localparam int IXW  = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic            vld = 0;
  logic [IDW-1:0]  rx_id = '0;
  logic            rx_ide = 0, rx_rtr = 0, rx_rb = 0;
  logic [NOBJ*IDW-1:0] c_tag = '0, c_msk = '0;
  logic [NOBJ-1:0] c_rtag = '0, c_rbtag = '0, c_ext = '0, c_rchk = '0,
                   c_ichk = '0, c_en = '0, c_rx = '0;
  logic            hit;
  logic [IXW-1:0]  idx;
  logic [NOBJ-1:0] vec;

  int nchk = 0, nfail = 0;
  bit done = 0;

  can_accept_filter #(.NOBJ(NOBJ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(vld),
    .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr), .rx_rb_i(rx_rb),
    .cfg_tag_i(c_tag), .cfg_msk_i(c_msk), .cfg_rtr_tag_i(c_rtag),
    .cfg_rb_tag_i(c_rbtag), .cfg_ext_i(c_ext), .cfg_rtr_chk_i(c_rchk),
    .cfg_ide_chk_i(c_ichk), .cfg_en_i(c_en), .cfg_rx_i(c_rx),
    .hit_o(hit), .hit_idx_o(idx), .hit_vec_o(vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_hit(int o, logic [IDW-1:0] id, logic ide, logic rtr, logic rb);
    logic [IDW-1:0] span;
    if (!c_en[o] || !c_rx[o]) return 0;
    span = c_ext[o] ? {IDW{1'b1}} : {11'h7ff, 18'h0};
    if (((id ^ c_tag[o*IDW +: IDW]) & c_msk[o*IDW +: IDW] & span) != 0) return 0;
    if (rb != c_rbtag[o]) return 0;
    if (c_rchk[o] && rtr != c_rtag[o]) return 0;
    if (!c_ext[o] && ide) return 0;
    if (c_ext[o] && c_ichk[o] && !ide) return 0;
    return 1;
  endfunction

  logic [NOBJ-1:0] e_vec;
  logic [IXW-1:0]  e_idx;

  task automatic send(string req, logic [IDW-1:0] id, logic ide, logic rtr, logic rb);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_rb = rb; vld = 1;
    e_vec = '0; e_idx = '0;
    for (int o = NOBJ - 1; o >= 0; o--) begin
      e_vec[o] = model_hit(o, id, ide, rtr, rb);
      if (e_vec[o]) e_idx = IXW'(o);
    end
    @(negedge clk);
    vld = 0;
    chk({req, " hit"}, 32'(hit), 32'(|e_vec));
    chk({req, " idx"}, 32'(idx), 32'(e_idx));
    chk({req, " vec"}, 32'(vec), 32'(e_vec));
  endtask

  task automatic clear_cfg();
    c_tag = '0; c_msk = '0; c_rtag = '0; c_rbtag = '0; c_ext = '0;
    c_rchk = '0; c_ichk = '0; c_en = '0; c_rx = '0;
  endtask

  task automatic set_slot(int o, logic [IDW-1:0] tag, logic [IDW-1:0] msk, logic ext,
                          logic rchk, logic ichk, logic rtag, logic rbtag);
    c_tag[o*IDW +: IDW] = tag; c_msk[o*IDW +: IDW] = msk;
    c_ext[o] = ext; c_rchk[o] = rchk; c_ichk[o] = ichk;
    c_rtag[o] = rtag; c_rbtag[o] = rbtag; c_en[o] = 1; c_rx[o] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [IDW-1:0] t;
    logic [IDW-1:0] h_id;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset hit", 32'(hit), 0);
    chk("R1 reset idx", 32'(idx), 0);
    chk("R1 reset vec", 32'(vec), 0);
    rst_n = 1;
    @(negedge clk);

    // R4 extended exact compare with IDE check
    t = 29'h1abc_1234;
    clear_cfg();
    set_slot(3, t, '1, 1, 1, 1, 0, 0);
    send("R4 exact", t, 1, 0, 0);
    chk("R1 owner", 32'(idx), 3);
    send("R4 low bit", t ^ 29'h1, 1, 0, 0);
    chk("R10 miss flag", 32'(hit), 0);
    send("R4 ide0", t, 0, 0, 0);
    c_ichk[3] = 0;
    send("R4 ide ignored", t, 0, 0, 0);
    chk("R4 ide ignored idx", 32'(hit), 1);
    // R2 mask don't care
    c_msk[3*IDW] = 1'b0;
    send("R2 masked bit", t ^ 29'h1, 1, 0, 0);
    chk("R2 masked hit", 32'(hit), 1);
    send("R2 unmasked bit", t ^ 29'h2, 1, 0, 0);
    // R5 RTR
    c_rchk[3] = 0;
    send("R5 rtr ignored", t, 1, 1, 0);
    chk("R5 rtr ignored hit", 32'(hit), 1);
    c_rchk[3] = 1;
    send("R5 rtr checked", t, 1, 1, 0);
    chk("R5 rtr miss", 32'(hit), 0);
    // R6 reserved bit
    send("R6 rb", t, 1, 0, 1);
    chk("R6 rb miss", 32'(hit), 0);

    // R3 standard slot
    clear_cfg();
    set_slot(5, {11'h5a3, 18'h0}, '1, 0, 0, 0, 0, 0);
    send("R3 std low bits", {11'h5a3, 18'h2ffff}, 0, 0, 0);
    chk("R3 std hit", 32'(idx), 5);
    send("R3 std ide1", {11'h5a3, 18'h0}, 1, 0, 0);
    chk("R3 std ide miss", 32'(hit), 0);
    send("R3 std upper", {11'h5a2, 18'h0}, 0, 0, 0);

    // R8 priority, R7 off/transmit
    clear_cfg();
    set_slot(2, '0, '0, 1, 0, 0, 0, 0);
    set_slot(7, '0, '0, 1, 0, 0, 0, 0);
    set_slot(14, '0, '0, 1, 0, 0, 0, 0);
    send("R8 multi", 29'h0dead, 1, 0, 0);
    chk("R8 lowest", 32'(idx), 2);
    chk("R8 vec", 32'(vec), 32'h4084);
    c_en[2] = 0;
    send("R7 disabled", 29'h0dead, 1, 0, 0);
    chk("R7 next owner", 32'(idx), 7);
    c_rx[7] = 0;
    send("R7 transmit", 29'h0dead, 1, 0, 0);
    chk("R7 top index", 32'(idx), 14);

    // R9 hold between strobes
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_id = 29'($urandom); c_en = '0;
      chk("R9 hold hit", 32'(hit), 1);
      chk("R9 hold idx", 32'(idx), 14);
      chk("R9 hold vec", 32'(vec), 32'h4000);
    end

    // random
    for (int it = 0; it < 400; it++) begin
      int o;
      logic [IDW-1:0] id;
      if (it % 25 == 0) begin
        clear_cfg();
        for (int s = 0; s < NOBJ; s++) begin
          logic [IDW-1:0] tg;
          tg = ($urandom % 3 == 0) ? 29'h15555555 : 29'($urandom);
          set_slot(s, tg, ($urandom % 2) ? '1 : 29'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
          c_en[s] = ($urandom % 5 != 0);
          c_rx[s] = ($urandom % 5 != 0);
        end
      end
      o = $urandom % NOBJ;
      id = c_tag[o*IDW +: IDW] ^ (29'($urandom) & ~c_msk[o*IDW +: IDW]);
      if (!c_ext[o]) id[17:0] = 18'($urandom);
      if ($urandom % 8 == 0) id ^= 29'(1) << ($urandom % IDW);
      send("R8 random", id,
           ($urandom % 6 == 0) ? !c_ext[o] : c_ext[o],
           ($urandom % 6 == 0) ? !c_rtag[o] : c_rtag[o],
           ($urandom % 8 == 0) ? !c_rbtag[o] : c_rbtag[o]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule